// File: doc/BRIEF.md
# TCM Address Router With Cycle Accounting

This block sits on the data side of a processor core and steers every load and store to one of three targets. Two small tightly coupled RAMs live inside it: an instruction-side array and a data-side array. Everything else goes out through an external bus port. Each request carries an address, a size (byte, halfword or word), a write flag, write data and a flag that marks it as non-sequential. The two address windows are set by plain configuration inputs, which a coprocessor register block drives. Those inputs are an enable and a size code for each window, plus a base for the data window.

The block also keeps a running access-cost counter. A hit in either internal RAM costs one cycle. An external access takes its cost from a timing table that arrives as an input vector. The table is indexed by a zone number, which the external bus returns with its response, and by the width of the access. A non-sequential external access restarts the counter from the table value. A sequential one adds the table value to the counter.

Requests and responses use valid/ready handshakes, and only one access is in flight at a time. `req_ready` is high only when the block is idle. A response, which also acknowledges a write, stays on `rsp_valid` with stable data and region until `rsp_ready` is sampled high. The external port holds its request stable until `ext_req_ready` is seen. It takes `ext_rsp_valid` only in the cycles after that handshake.

Top module: `tcm_router`

## Requirements
- R1: Sizes are encoded 0 = byte, 1 = halfword, 2 = word. Before any decode, a halfword clears address bit 0 and a word clears bits 1:0. The cleared address is the one shown on `ext_req_addr`.
- R2: When `itcm_en` is high, an address below 512 << `itcm_code` hits the instruction RAM (region 0). The limit is computed in 33 bits, so code 23 spans the whole space and codes 24 and above match nothing. This test comes first: an address inside both windows is served as region 0.
- R3: The data window has base `dtcm_cfg[31:12]` << 12 and size 512 << `dtcm_cfg[5:1]`. When `dtcm_en` is high, an address with base ≤ address < base + size (33-bit sum) hits the data RAM (region 1). When disabled, the data window never matches.
- R4: The instruction RAM is indexed by address & (2^IMEM_AW − 1). The data RAM is indexed by (address − base) & (2^DMEM_AW − 1). A window larger than its array therefore mirrors the array.
- R5: Every accepted access that hits either RAM adds exactly 1 to `cyc_count`, on the accepting clock edge.
- R6: An external access updates `cyc_count` on the edge that takes `ext_rsp_valid`. A non-sequential access loads the selected table field, and a sequential access adds it, modulo 2^CW. Field f = zone·4 + k sits at `zone_timing[f·TW +: TW]`, where the zone comes from `ext_rsp_zone`.
- R7: Byte and halfword external accesses use k = 0 (non-sequential) or k = 1 (sequential). Word accesses use k = 2 or k = 3.
- R8: A write changes only its byte lanes, which are little-endian. A byte uses lane addr[1:0], a halfword uses lanes 0–1 or 2–3 according to addr[1], and a word uses all four. Write data is replicated across lanes. The same mask and data appear on `ext_req_be` and `ext_req_wdata`.
- R9: Read data returns the addressed byte or halfword zero-extended at bit 0, or the whole word. A write response carries zero.
- R10: A RAM hit raises `rsp_valid` in the cycle after acceptance. `rsp_valid`, `rsp_rdata` and `rsp_region` hold until `rsp_ready` is taken, and `req_ready` is low while an access is in flight.
- R11: An external access raises `ext_req_valid` in the cycle after acceptance, and holds it and its fields until `ext_req_ready`. The external response is forwarded as a response in the following cycle.
- R12: `rsp_region` reports 0 for the instruction RAM, 1 for the data RAM and 2 for the external port.
- R13: After reset, `req_ready` is high, `rsp_valid` and `ext_req_valid` are low, and `cyc_count` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| itcm_en | input | 1 | Instruction window enable |
| itcm_code | input | 5 | Instruction window size code |
| dtcm_en | input | 1 | Data window enable |
| dtcm_cfg | input | 32 | Data window base [31:12] and size code [5:1] |
| zone_timing | input | 2^ZW·4·TW | Per-zone cost table |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with valid |
| req_addr | input | 32 | Byte address |
| req_size | input | 2 | Access size |
| req_write | input | 1 | Write when high |
| req_wdata | input | 32 | Write data, low bits significant |
| req_nonseq | input | 1 | Non-sequential access flag |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response taken |
| rsp_rdata | output | 32 | Read data, zero for writes |
| rsp_region | output | 2 | Serving target |
| ext_req_valid | output | 1 | External request valid |
| ext_req_ready | input | 1 | External request taken |
| ext_req_addr | output | 32 | Aligned external address |
| ext_req_size | output | 2 | External access size |
| ext_req_write | output | 1 | External write flag |
| ext_req_be | output | 4 | External byte lanes |
| ext_req_wdata | output | 32 | Lane-replicated write data |
| ext_rsp_valid | input | 1 | External response valid |
| ext_rsp_rdata | input | 32 | External bus word |
| ext_rsp_zone | input | ZW | Timing zone of the access |
| cyc_count | output | CW | Accumulated access cost |

## Verification
Both windows can claim the same address in the same cycle. The bench provokes this in two ways. It moves the data base onto the instruction window, and it widens the instruction window over the data base. It then judges that the response region is 0 and that the data comes from the instruction array's model. A RAM hit and a counter update also fall on one edge. Each access compares the count against a separately tracked expectation, across whole-window sweeps with mirroring, boundary addresses on both sides of each window, and every zone and width of external access.

// File: rtl/tcmr_pkg.sv
package tcmr_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } acc_size_t;

  typedef enum logic [1:0] {
    RG_ITCM = 2'd0,
    RG_DTCM = 2'd1,
    RG_EXT  = 2'd2
  } region_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_EXT_REQ,
    ST_EXT_WAIT,
    ST_RESP
  } rstate_t;

  // clear the low address bits that the access size does not use
  function automatic logic [31:0] align_addr(input logic [31:0] a, input logic [1:0] sz);
    case (sz)
      2'd0:    return a;
      2'd1:    return {a[31:1], 1'b0};
      default: return {a[31:2], 2'b00};
    endcase
  endfunction

  function automatic logic [3:0] lane_mask(input logic [1:0] off, input logic [1:0] sz);
    case (sz)
      2'd0:    return 4'b0001 << off;
      2'd1:    return off[1] ? 4'b1100 : 4'b0011;
      default: return 4'b1111;
    endcase
  endfunction

  function automatic logic [31:0] lane_spread(input logic [31:0] d, input logic [1:0] sz);
    case (sz)
      2'd0:    return {4{d[7:0]}};
      2'd1:    return {2{d[15:0]}};
      default: return d;
    endcase
  endfunction

  function automatic logic [31:0] lane_pick(input logic [31:0] w, input logic [1:0] off,
                                            input logic [1:0] sz);
    logic [31:0] s;
    s = w >> {off, 3'b000};
    case (sz)
      2'd0:    return {24'd0, s[7:0]};
      2'd1:    return {16'd0, s[15:0]};
      default: return w;
    endcase
  endfunction

endpackage

// File: rtl/tcmr_decode.sv
module tcmr_decode
  import tcmr_pkg::*;
#(
  parameter int IMEM_AW = 12,
  parameter int DMEM_AW = 11
) (
  input  logic [31:0]        addr,
  input  logic [1:0]         size,
  input  logic               itcm_en,
  input  logic [4:0]         itcm_code,
  input  logic               dtcm_en,
  input  logic [31:0]        dtcm_cfg,
  output logic [31:0]        addr_al,
  output logic [1:0]         region,
  output logic [IMEM_AW-3:0] iidx,
  output logic [DMEM_AW-3:0] didx
);

  logic [32:0] ilimit;
  logic [31:0] dbase;
  logic [32:0] dend;
  logic [31:0] doff;
  logic        ihit;
  logic        dhit;

  assign addr_al = align_addr(addr, size);

  // window lengths are 512 << code, kept in 33 bits so the top of memory is reachable
  assign ilimit = itcm_en ? (33'd512 << itcm_code) : 33'd0;
  assign dbase  = {dtcm_cfg[31:12], 12'h000};
  assign dend   = {1'b0, dbase} + (33'd512 << dtcm_cfg[5:1]);

  assign ihit = ({1'b0, addr_al} < ilimit);
  assign dhit = dtcm_en && (addr_al >= dbase) && ({1'b0, addr_al} < dend);

  always_comb begin
    if (ihit)      region = RG_ITCM;
    else if (dhit) region = RG_DTCM;
    else           region = RG_EXT;
  end

  assign doff = addr_al - dbase;
  assign iidx = addr_al[IMEM_AW-1:2];
  assign didx = doff[DMEM_AW-1:2];

  logic unused_bits;
  assign unused_bits = ^{doff[31:DMEM_AW], doff[1:0], dtcm_cfg[11:6], dtcm_cfg[0]};

endmodule

// File: rtl/tcmr_lane_ram.sv
module tcmr_lane_ram #(
  parameter int WAW = 10
) (
  input  logic           clk,
  input  logic           en,
  input  logic           we,
  input  logic [3:0]     be,
  input  logic [WAW-1:0] idx,
  input  logic [31:0]    wdata,
  output logic [31:0]    rdata
);

  localparam int DEPTH = 1 << WAW;

  for (genvar ln = 0; ln < 4; ln++) begin : g_lane
    logic [7:0] store [DEPTH];
    logic [7:0] q;
    always_ff @(posedge clk) begin
      if (en) begin
        if (we && be[ln]) store[idx] <= wdata[8*ln +: 8];
        q <= store[idx];
      end
    end
    assign rdata[8*ln +: 8] = q;
  end

endmodule

// File: rtl/tcmr_cycle_acc.sv
module tcmr_cycle_acc #(
  parameter int ZW = 2,
  parameter int TW = 5,
  parameter int CW = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       tcm_tick,
  input  logic                       ext_tick,
  input  logic                       ext_word,
  input  logic                       ext_nonseq,
  input  logic [ZW-1:0]              ext_zone,
  input  logic [(1<<ZW)*4*TW-1:0]    timing,
  output logic [CW-1:0]              count
);

  logic [ZW+1:0] fidx;
  logic [TW-1:0] field;

  // field layout per zone: narrow non-seq, narrow seq, word non-seq, word seq
  assign fidx  = {ext_zone, ext_word, ~ext_nonseq};
  assign field = timing[int'(fidx)*TW +: TW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
    end else if (tcm_tick) begin
      count <= count + CW'(1);
    end else if (ext_tick) begin
      if (ext_nonseq) count <= CW'(field);
      else            count <= count + CW'(field);
    end
  end

endmodule

// File: rtl/tcm_router.sv
module tcm_router
  import tcmr_pkg::*;
#(
  parameter int IMEM_AW = 12,
  parameter int DMEM_AW = 11,
  parameter int ZW      = 2,
  parameter int TW      = 5,
  parameter int CW      = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        itcm_en,
  input  logic [4:0]                  itcm_code,
  input  logic                        dtcm_en,
  input  logic [31:0]                 dtcm_cfg,
  input  logic [(1<<ZW)*4*TW-1:0]     zone_timing,
  input  logic                        req_valid,
  output logic                        req_ready,
  input  logic [31:0]                 req_addr,
  input  logic [1:0]                  req_size,
  input  logic                        req_write,
  input  logic [31:0]                 req_wdata,
  input  logic                        req_nonseq,
  output logic                        rsp_valid,
  input  logic                        rsp_ready,
  output logic [31:0]                 rsp_rdata,
  output logic [1:0]                  rsp_region,
  output logic                        ext_req_valid,
  input  logic                        ext_req_ready,
  output logic [31:0]                 ext_req_addr,
  output logic [1:0]                  ext_req_size,
  output logic                        ext_req_write,
  output logic [3:0]                  ext_req_be,
  output logic [31:0]                 ext_req_wdata,
  input  logic                        ext_rsp_valid,
  input  logic [31:0]                 ext_rsp_rdata,
  input  logic [ZW-1:0]               ext_rsp_zone,
  output logic [CW-1:0]               cyc_count
);

  localparam int IWA = IMEM_AW - 2;
  localparam int DWA = DMEM_AW - 2;

  rstate_t     st;
  logic        accept;
  logic [31:0] dec_addr;
  logic [1:0]  dec_region;
  logic [IWA-1:0] dec_iidx;
  logic [DWA-1:0] dec_didx;
  logic [3:0]  acc_be;
  logic [31:0] acc_wd;
  logic [31:0] iq, dq;

  logic [31:0] l_addr;
  logic [1:0]  l_size;
  logic        l_write;
  logic        l_nonseq;
  logic [1:0]  l_region;
  logic [31:0] l_wdata;
  logic [31:0] l_ext;

  tcmr_decode #(.IMEM_AW(IMEM_AW), .DMEM_AW(DMEM_AW)) u_dec (
    .addr      (req_addr),
    .size      (req_size),
    .itcm_en   (itcm_en),
    .itcm_code (itcm_code),
    .dtcm_en   (dtcm_en),
    .dtcm_cfg  (dtcm_cfg),
    .addr_al   (dec_addr),
    .region    (dec_region),
    .iidx      (dec_iidx),
    .didx      (dec_didx)
  );

  assign req_ready = (st == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign acc_be    = lane_mask(dec_addr[1:0], req_size);
  assign acc_wd    = lane_spread(req_wdata, req_size);

  tcmr_lane_ram #(.WAW(IWA)) u_iram (
    .clk   (clk),
    .en    (accept && dec_region == RG_ITCM),
    .we    (req_write),
    .be    (acc_be),
    .idx   (dec_iidx),
    .wdata (acc_wd),
    .rdata (iq)
  );

  tcmr_lane_ram #(.WAW(DWA)) u_dram (
    .clk   (clk),
    .en    (accept && dec_region == RG_DTCM),
    .we    (req_write),
    .be    (acc_be),
    .idx   (dec_didx),
    .wdata (acc_wd),
    .rdata (dq)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      l_addr   <= '0;
      l_size   <= '0;
      l_write  <= 1'b0;
      l_nonseq <= 1'b0;
      l_region <= RG_EXT;
      l_wdata  <= '0;
      l_ext    <= '0;
    end else begin
      case (st)
        ST_IDLE: if (req_valid) begin
          l_addr   <= dec_addr;
          l_size   <= req_size;
          l_write  <= req_write;
          l_nonseq <= req_nonseq;
          l_region <= dec_region;
          l_wdata  <= acc_wd;
          st       <= (dec_region == RG_EXT) ? ST_EXT_REQ : ST_RESP;
        end
        ST_EXT_REQ:  if (ext_req_ready) st <= ST_EXT_WAIT;
        ST_EXT_WAIT: if (ext_rsp_valid) begin
          l_ext <= ext_rsp_rdata;
          st    <= ST_RESP;
        end
        ST_RESP:     if (rsp_ready) st <= ST_IDLE;
        default:     st <= ST_IDLE;
      endcase
    end
  end

  tcmr_cycle_acc #(.ZW(ZW), .TW(TW), .CW(CW)) u_cyc (
    .clk        (clk),
    .rst_n      (rst_n),
    .tcm_tick   (accept && dec_region != RG_EXT),
    .ext_tick   (st == ST_EXT_WAIT && ext_rsp_valid),
    .ext_word   (l_size == SZ_WORD),
    .ext_nonseq (l_nonseq),
    .ext_zone   (ext_rsp_zone),
    .timing     (zone_timing),
    .count      (cyc_count)
  );

  logic [31:0] src_word;
  always_comb begin
    case (l_region)
      RG_ITCM: src_word = iq;
      RG_DTCM: src_word = dq;
      default: src_word = l_ext;
    endcase
  end

  assign rsp_valid     = (st == ST_RESP);
  assign rsp_region    = l_region;
  assign rsp_rdata     = l_write ? 32'd0 : lane_pick(src_word, l_addr[1:0], l_size);

  assign ext_req_valid = (st == ST_EXT_REQ);
  assign ext_req_addr  = l_addr;
  assign ext_req_size  = l_size;
  assign ext_req_write = l_write;
  assign ext_req_be    = lane_mask(l_addr[1:0], l_size);
  assign ext_req_wdata = l_wdata;

endmodule

// File: rtl/tcmr_checker.sv
module tcmr_checker #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          rsp_valid,
  input logic          rsp_ready,
  input logic [31:0]   rsp_rdata,
  input logic [1:0]    rsp_region,
  input logic          ext_req_valid,
  input logic          ext_req_ready,
  input logic [31:0]   ext_req_addr,
  input logic [1:0]    ext_req_size,
  input logic [1:0]    acc_region,
  input logic [CW-1:0] cyc_count
);

  AST_EXT_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    ext_req_valid |-> ((ext_req_size == 2'd0) || (ext_req_addr[0] == 1'b0 &&
      (ext_req_size == 2'd1 || ext_req_addr[1] == 1'b0)))); // R1

  AST_TCM_COST_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && acc_region != 2'd2) |=> cyc_count == $past(cyc_count) + CW'(1)); // R5

  AST_TCM_NEXT_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && acc_region != 2'd2) |=> (rsp_valid && rsp_region == $past(acc_region))); // R10

  AST_RSP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata) && $stable(rsp_region))); // R10

  AST_EXT_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && acc_region == 2'd2) |=> ext_req_valid); // R11

  AST_EXT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_req_valid && !ext_req_ready) |=> (ext_req_valid && $stable(ext_req_addr))); // R11

  AST_EXT_REGION: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ext_req_valid) |-> !rsp_valid); // R12

endmodule

bind tcm_router tcmr_checker #(.CW(CW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .rsp_valid     (rsp_valid),
  .rsp_ready     (rsp_ready),
  .rsp_rdata     (rsp_rdata),
  .rsp_region    (rsp_region),
  .ext_req_valid (ext_req_valid),
  .ext_req_ready (ext_req_ready),
  .ext_req_addr  (ext_req_addr),
  .ext_req_size  (ext_req_size),
  .acc_region    (dec_region),
  .cyc_count     (cyc_count)
);

// File: tb/sim_tcm_router.sv
`timescale 1ns/1ps
module sim_tcm_router;

  localparam int IAW = 8;
  localparam int DAW = 7;
  localparam int ZW  = 2;
  localparam int TW  = 5;
  localparam int CW  = 16;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n;
  logic        ien, den;
  logic [4:0]  icode;
  logic [31:0] dcfg;
  logic [(1<<ZW)*4*TW-1:0] tmg;
  logic        req_valid, req_ready, req_write, req_nonseq;
  logic [31:0] req_addr, req_wdata;
  logic [1:0]  req_size;
  logic        rsp_valid, rsp_ready;
  logic [31:0] rsp_rdata;
  logic [1:0]  rsp_region;
  logic        ext_req_valid, ext_req_ready, ext_req_write;
  logic [31:0] ext_req_addr, ext_req_wdata;
  logic [1:0]  ext_req_size;
  logic [3:0]  ext_req_be;
  logic        ext_rsp_valid;
  logic [31:0] ext_rsp_rdata;
  logic [ZW-1:0] ext_rsp_zone;
  logic [CW-1:0] cyc_count;

  tcm_router #(.IMEM_AW(IAW), .DMEM_AW(DAW), .ZW(ZW), .TW(TW), .CW(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .itcm_en(ien), .itcm_code(icode), .dtcm_en(den),
    .dtcm_cfg(dcfg), .zone_timing(tmg), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_size(req_size), .req_write(req_write), .req_wdata(req_wdata),
    .req_nonseq(req_nonseq), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_rdata(rsp_rdata), .rsp_region(rsp_region), .ext_req_valid(ext_req_valid),
    .ext_req_ready(ext_req_ready), .ext_req_addr(ext_req_addr), .ext_req_size(ext_req_size),
    .ext_req_write(ext_req_write), .ext_req_be(ext_req_be), .ext_req_wdata(ext_req_wdata),
    .ext_rsp_valid(ext_rsp_valid), .ext_rsp_rdata(ext_rsp_rdata),
    .ext_rsp_zone(ext_rsp_zone), .cyc_count(cyc_count)
  );

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;
  logic [7:0] im [256];
  logic [7:0] dm [128];
  logic [CW-1:0] exp_cnt;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] al_of(input logic [31:0] a, input logic [1:0] sz);
    if (sz == 2'd1) return a & ~32'd1;
    if (sz == 2'd2) return a & ~32'd3;
    return a;
  endfunction

  function automatic logic [1:0] exp_region(input logic [31:0] a);
    logic [32:0] il, dl;
    logic [31:0] db;
    il = ien ? (33'd512 << icode) : 33'd0;
    if ({1'b0, a} < il) return 2'd0;
    db = {dcfg[31:12], 12'h000};
    dl = {1'b0, db} + (33'd512 << dcfg[5:1]);
    if (den && a >= db && {1'b0, a} < dl) return 2'd1;
    return 2'd2;
  endfunction

  function automatic logic [3:0] exp_be(input logic [1:0] off, input logic [1:0] sz);
    if (sz == 2'd0) return 4'd1 << off;
    if (sz == 2'd1) return off[1] ? 4'hC : 4'h3;
    return 4'hF;
  endfunction

  function automatic logic [31:0] ext_word(input logic [31:0] wa);
    return {wa[15:0] ^ 16'h5A5A, wa[31:16] ^ 16'h0F0F};
  endfunction

  function automatic logic [31:0] pick(input logic [31:0] w, input logic [1:0] off,
                                       input logic [1:0] sz);
    logic [31:0] s;
    s = w >> (8 * off);
    if (sz == 2'd0) return s & 32'hFF;
    if (sz == 2'd1) return s & 32'hFFFF;
    return w;
  endfunction

  // one access through the request, external and response channels
  task automatic acc(input logic [31:0] a, input logic [1:0] sz, input bit wr,
                     input logic [31:0] wd, input bit ns, input string tag, input int hold);
    logic [31:0] al, wa, spread, word, exp_rd, got;
    logic [1:0]  rg;
    logic [3:0]  be;
    int phase, lat;
    bit done;
    al = al_of(a, sz);
    wa = al & ~32'd3;
    rg = exp_region(al);
    be = exp_be(al[1:0], sz);
    spread = (sz == 2'd0) ? {4{wd[7:0]}} : (sz == 2'd1) ? {2{wd[15:0]}} : wd;
    word = 32'd0;
    for (int i = 0; i < 4; i++) begin
      if (rg == 2'd0) begin
        if (wr && be[i]) im[(wa + 32'(i)) & 32'hFF] = spread[8*i +: 8];
        word[8*i +: 8] = im[(wa + 32'(i)) & 32'hFF];
      end else if (rg == 2'd1) begin
        if (wr && be[i]) dm[(wa + 32'(i) - {dcfg[31:12], 12'h000}) & 32'h7F] = spread[8*i +: 8];
        word[8*i +: 8] = dm[(wa + 32'(i) - {dcfg[31:12], 12'h000}) & 32'h7F];
      end else begin
        word = ext_word(wa);
      end
    end
    exp_rd = wr ? 32'd0 : pick(word, al[1:0], sz);
    if (rg != 2'd2) exp_cnt = exp_cnt + 1'b1;
    else begin
      logic [31:0] tv;
      tv = 32'(al[29:28]) * 4 + ((sz == 2'd2) ? 2 : 0) + (ns ? 0 : 1) + 1;
      exp_cnt = ns ? CW'(tv) : exp_cnt + CW'(tv);
    end

    @(negedge clk);
    check(req_ready === 1'b1, "R10", "ready before request", 64'(req_ready), 64'd1);
    req_valid = 1'b1; req_addr = a; req_size = sz; req_write = wr;
    req_wdata = wd; req_nonseq = ns;
    @(negedge clk);
    req_valid = 1'b0;
    phase = 0; done = 1'b0; lat = 0;
    for (int n = 1; n < 40 && !done; n++) begin
      if (n > 1) @(negedge clk);
      ext_req_ready = 1'b0; ext_rsp_valid = 1'b0;
      if (phase == 1) begin
        ext_rsp_valid = 1'b1; ext_rsp_rdata = ext_word(wa); ext_rsp_zone = al[29:28];
        phase = 2;
      end else if (rsp_valid) begin
        lat = n;
        got = rsp_rdata;
        for (int h = 0; h < hold; h++) begin
          @(negedge clk);
          check(rsp_valid && rsp_rdata == got, "R10", "held response",
                64'(rsp_rdata), 64'(got));
        end
        check(rsp_region == rg, "R12", "region", 64'(rsp_region), 64'(rg));
        check(rsp_rdata == exp_rd, (rg == 2'd2) ? "R9" : "R8", "read data",
              64'(rsp_rdata), 64'(exp_rd));
        check(cyc_count == exp_cnt, (rg == 2'd2) ? "R6" : "R5", "cycle count",
              64'(cyc_count), 64'(exp_cnt));
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
        done = 1'b1;
      end else if (ext_req_valid && phase == 0) begin
        check(rg == 2'd2 && n == 1, "R11", "external launch cycle", 64'(n), 64'd1);
        check(ext_req_addr == al && ext_req_be == be && ext_req_write == wr &&
              (!wr || ext_req_wdata == spread), "R1",
              "external address/lanes", {ext_req_addr, 28'd0, ext_req_be}, {al, 28'd0, be});
        ext_req_ready = 1'b1;
        phase = 1;
      end
    end
    check(done, tag, "response seen", 64'(done), 64'd1);
    if (rg != 2'd2) check(lat == 1, "R10", "RAM response latency", 64'(lat), 64'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog run did not complete actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; ien = 1'b1; icode = 5'd0; den = 1'b1; dcfg = 32'h0000_1000;
    for (int z = 0; z < 4; z++)
      for (int k = 0; k < 4; k++)
        tmg[(z*4+k)*TW +: TW] = TW'(z*4 + k + 1);
    req_valid = 0; req_addr = 0; req_size = 0; req_write = 0; req_wdata = 0; req_nonseq = 0;
    rsp_ready = 0; ext_req_ready = 0; ext_rsp_valid = 0; ext_rsp_rdata = 0; ext_rsp_zone = 0;
    exp_cnt = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready && !rsp_valid && !ext_req_valid && cyc_count == 0, "R13", "reset state",
          {60'd0, req_ready, rsp_valid, ext_req_valid, 1'b0}, 64'h8);

    // R4 R8: fill the instruction array, then overwrite through the mirror
    for (int a = 0; a < 256; a += 4) acc(32'(a), 2'd2, 1, 32'(a) * 32'h01010101 ^ 32'hC3A50000, 1, "R8", 0);
    for (int a = 256; a < 512; a += 7) acc(32'(a), 2'd0, 1, 32'(a) ^ 32'h3C, 0, "R4", 0);
    for (int a = 1; a < 512; a += 10) acc(32'(a), 2'd1, 1, 32'(a) * 32'd977, 1, "R1", 0);
    for (int a = 0; a < 512; a++)
      for (int s = 0; s < 3; s++) acc(32'(a), 2'(s), 0, 0, a[0], "R4", 0);

    // data window sweep with mirroring past 128 bytes
    for (int a = 0; a < 128; a += 4) acc(32'h1000 + 32'(a), 2'd2, 1, 32'(a) * 32'h00010203 + 32'h1234, 0, "R8", 0);
    for (int a = 3; a < 512; a += 9) acc(32'h1000 + 32'(a), 2'd0, 1, 32'(a) + 32'h80, 1, "R8", 0);
    for (int a = 0; a < 512; a++)
      for (int s = 0; s < 3; s++) acc(32'h1000 + 32'(a), 2'(s), 0, 0, 1, "R3", 0);

    // window edges
    acc(32'h1FF, 2'd0, 0, 0, 1, "R2", 0);
    acc(32'h200, 2'd0, 0, 0, 1, "R2", 0);
    acc(32'hFFF, 2'd0, 0, 0, 1, "R3", 0);
    acc(32'h11FF, 2'd0, 0, 0, 1, "R3", 0);
    acc(32'h1200, 2'd2, 0, 0, 1, "R3", 0);

    // both windows claim the address: instruction side wins
    dcfg = 32'h0000_0000;
    acc(32'h10, 2'd2, 0, 0, 1, "R2", 0);
    dcfg = 32'h0000_1000; icode = 5'd4;
    acc(32'h1004, 2'd2, 0, 0, 0, "R2", 0);
    icode = 5'd0;

    // disabled windows fall through to the bus
    ien = 1'b0;
    acc(32'h0, 2'd2, 0, 0, 1, "R2", 0);
    den = 1'b0;
    acc(32'h1000, 2'd2, 1, 32'hDEADBEEF, 1, "R3", 0);
    ien = 1'b1; den = 1'b1;

    // external zones, widths, sequential chains
    for (int z = 0; z < 4; z++)
      for (int s = 0; s < 3; s++) begin
        acc((32'(z) << 28) | 32'h0200_0000 | 32'(s * 5), 2'(s), 0, 0, 1, "R7", 0);
        acc((32'(z) << 28) | 32'h0200_0010 | 32'(s * 3), 2'(s), 0, 0, 0, "R6", 0);
        acc((32'(z) << 28) | 32'h0200_0021 + 32'(s), 2'(s), 1, 32'h89ABCDEF, 0, "R8", 0);
      end
    // a RAM hit between external accesses keeps adding
    acc(32'h4, 2'd2, 0, 0, 0, "R5", 0);
    acc(32'h3000_0100, 2'd2, 0, 0, 0, "R6", 0);

    // size-code corners: whole space, then nothing
    icode = 5'd23;
    acc(32'hFFFF_FFFC, 2'd2, 0, 0, 1, "R2", 0);
    icode = 5'd24;
    acc(32'h0, 2'd2, 0, 0, 1, "R2", 0);
    ien = 1'b0; dcfg = 32'hFFFF_F000 | (32'd4 << 1);
    acc(32'hFFFF_FFFF, 2'd0, 1, 32'h5E, 1, "R3", 0);
    acc(32'hFFFF_FFFC, 2'd2, 0, 0, 1, "R3", 0);
    ien = 1'b1; icode = 5'd0; dcfg = 32'h0000_1000;

    // response back-pressure
    acc(32'h8, 2'd2, 0, 0, 1, "R10", 3);
    acc(32'h0400_0000, 2'd1, 0, 0, 1, "R11", 2);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule